// File: doc/BRIEF.md
# I2C Command-Word Sequencer

This block is the master-side front end of an I2C controller. Software or a host engine pushes 10-bit command words into a 16-entry transmit queue. The sequencer reads them one at a time and turns each one into a request to a byte-level bus engine. Each request is one of four things: generate a start or repeated start and send an address byte, write a data byte, read one byte, or generate a stop. Start and stop are not set through control writes. They are flag bits carried in the queued words. A read length is the payload of the word that follows the address word.

The byte engine, which handles SCL/SDA timing, answers each request with a done strobe. The strobe comes with an acknowledge result, an arbitration-lost flag and, for reads, the received byte. The sequencer reports several things to the host:
- whether a transfer is in progress
- queue full, queue empty and queue occupancy
- one-cycle event pulses for transmit error, arbitration loss, queue empty, queue half-empty and the bus going idle

Received bytes are presented on a strobe-qualified output.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the queue reads empty and not full, occupancy reads 0, bus-busy is low, no engine request is raised and no event pulses.
- R2: A queued word with bit 8 set opens a transfer (or repeats the start inside one). It produces one engine request with operation code 0 (start plus address), carrying the word's bits 7:0 as the address byte. Bits 7:1 are the 7-bit slave address and bit 0 is the direction, 1 for read and 0 for write.
- R3: Inside an open transfer, a word with bit 8 clear produces operation code 1 (write) carrying its bits 7:0. If its bit 9 is set, operation code 3 (stop) follows.
- R4: After a start word with direction 1, the next word's bits 7:0 give a byte count N. N requests with operation code 2 (read) follow. The master-acknowledge output is 1 on every read except the last, where it is 0. Each received byte appears once on rx_data with rx_valid high. A stop follows if that word's bit 9 is set. N = 0 performs no reads.
- R5: A write-direction start word with bit 9 set produces only the address request followed by a stop.
- R6: The queue holds 16 words. tx_full is high with 16 stored, and a push while full is dropped. tx_occ reads the stored count minus one, or 0 when the queue is empty.
- R7: A pulse on fifo_reset empties the queue. The push of that same cycle is dropped, and tx_empty reads 1 on the next cycle.
- R8: A not-acknowledge on an address or a written byte pulses ev_tx_error, discards every queued word and issues a stop.
- R9: Arbitration loss pulses ev_arb_lost, discards every queued word, clears bus-busy and returns to idle without issuing a stop.
- R10: bus_busy rises when a start request is issued and falls when the stop completes, or when arbitration is lost. Every fall is followed one cycle later by an ev_bus_idle pulse.
- R11: If the queue runs dry while a transfer is open and no stop was requested, bus_busy stays high and no engine request is raised until another word arrives.
- R12: ev_tx_empty pulses when the queue becomes empty. ev_tx_half pulses when a removal brings the count down to exactly 8.
- R13: A data word (bit 8 clear) arriving while no transfer is open is discarded and pulses ev_tx_error.
- R14: An engine request holds its operation, byte and acknowledge outputs unchanged until the engine returns done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push wr_data into the queue |
| wr_data | input | 10 | Command word: bit 9 stop, bit 8 start, bits 7:0 payload |
| fifo_reset | input | 1 | Empty the queue |
| tx_full | output | 1 | Queue holds 16 words |
| tx_empty | output | 1 | Queue holds no word |
| tx_occ | output | 4 | Stored words minus one (0 when empty) |
| bus_busy | output | 1 | A transfer is open |
| eng_req | output | 1 | Request to the byte engine, held until eng_done |
| eng_op | output | 2 | 0 start+address, 1 write, 2 read, 3 stop |
| eng_byte | output | 8 | Address or data byte for the request |
| eng_mack | output | 1 | On reads: 1 master acknowledges, 0 master NACKs |
| eng_done | input | 1 | Engine finished the current request |
| eng_nak | input | 1 | Slave did not acknowledge (with eng_done) |
| eng_arb | input | 1 | Arbitration lost (with eng_done) |
| eng_rdata | input | 8 | Received byte (with eng_done on reads) |
| rx_valid | output | 1 | rx_data holds a newly received byte |
| rx_data | output | 8 | Received byte |
| ev_tx_error | output | 1 | Pulse: NACK or stray data word |
| ev_arb_lost | output | 1 | Pulse: arbitration lost |
| ev_tx_empty | output | 1 | Pulse: queue became empty |
| ev_tx_half | output | 1 | Pulse: queue drained to half |
| ev_bus_idle | output | 1 | Pulse: bus_busy fell |

## Verification
The following are checked on every cycle, for any stimulus:
- the request hold rule
- the full/occupancy relation
- the queue-reset effect
- the cycle after a NACK or an arbitration loss, meaning the error pulse, the flush, and the stop or its absence
- the busy/idle-event pairing

Only the bench's scenarios can show the other behaviours. Those are the exact order of engine operations built from a word stream, the acknowledge pattern across a multi-byte read, the hold on a dry queue, the dropped push when full, and the counts of half-empty and empty events. The bench compares each scenario against an operation list and a received-byte list that it builds itself.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int WORD_W   = 10;
  localparam int BIT_START = 8;
  localparam int BIT_STOP  = 9;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WRITE,
    ST_COUNT,
    ST_READ,
    ST_STOP
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [AW:0]   cnt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp_q];
  assign cnt     = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = ptr_inc(wp_q);
      if (do_pop)  rp_d = ptr_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + (AW+1)'(1);
        2'b01:   cnt_d = cnt_q - (AW+1)'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_head,
  output logic              fifo_pop,
  output logic              fifo_flush,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_byte,
  output logic              eng_mack,
  input  logic              eng_done,
  input  logic              eng_nak,
  input  logic              eng_arb,
  input  logic [7:0]        eng_rdata,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              busy,
  output logic              err_stb,
  output logic              arb_stb
);
  seq_state_e state_q, state_d;
  logic [7:0] byte_q, byte_d;
  logic [7:0] remain_q, remain_d;
  logic [7:0] rxd_q, rxd_d;
  logic       rd_q, rd_d;
  logic       stop_q, stop_d;
  logic       busy_q, busy_d;
  logic       rxv_q, rxv_d;

  always_comb begin
    state_d    = state_q;
    byte_d     = byte_q;
    remain_d   = remain_q;
    rxd_d      = rxd_q;
    rd_d       = rd_q;
    stop_d     = stop_q;
    busy_d     = busy_q;
    rxv_d      = 1'b0;
    fifo_pop   = 1'b0;
    fifo_flush = 1'b0;
    err_stb    = 1'b0;
    arb_stb    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          if (fifo_head[BIT_START]) begin
            byte_d  = fifo_head[7:0];
            rd_d    = fifo_head[0];
            stop_d  = fifo_head[BIT_STOP];
            busy_d  = 1'b1;
            state_d = ST_START;
          end else if (busy_q) begin
            byte_d  = fifo_head[7:0];
            stop_d  = fifo_head[BIT_STOP];
            state_d = ST_WRITE;
          end else begin
            err_stb = 1'b1;
          end
        end
      end
      ST_START, ST_WRITE: begin
        if (eng_done) begin
          if (eng_arb) begin
            fifo_flush = 1'b1;
            arb_stb    = 1'b1;
            busy_d     = 1'b0;
            state_d    = ST_IDLE;
          end else if (eng_nak) begin
            fifo_flush = 1'b1;
            err_stb    = 1'b1;
            state_d    = ST_STOP;
          end else if (state_q == ST_START && rd_q) begin
            state_d = ST_COUNT;
          end else begin
            state_d = stop_q ? ST_STOP : ST_IDLE;
          end
        end
      end
      ST_COUNT: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          remain_d = fifo_head[7:0];
          stop_d   = fifo_head[BIT_STOP];
          if (fifo_head[7:0] == 8'd0) begin
            state_d = fifo_head[BIT_STOP] ? ST_STOP : ST_IDLE;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (eng_done) begin
          if (eng_arb) begin
            fifo_flush = 1'b1;
            arb_stb    = 1'b1;
            busy_d     = 1'b0;
            state_d    = ST_IDLE;
          end else begin
            rxv_d    = 1'b1;
            rxd_d    = eng_rdata;
            remain_d = remain_q - 8'd1;
            if (remain_q == 8'd1) begin
              state_d = stop_q ? ST_STOP : ST_IDLE;
            end
          end
        end
      end
      ST_STOP: begin
        if (eng_done) begin
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      byte_q   <= '0;
      remain_q <= '0;
      rxd_q    <= '0;
      rd_q     <= 1'b0;
      stop_q   <= 1'b0;
      busy_q   <= 1'b0;
      rxv_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      byte_q   <= byte_d;
      remain_q <= remain_d;
      rxd_q    <= rxd_d;
      rd_q     <= rd_d;
      stop_q   <= stop_d;
      busy_q   <= busy_d;
      rxv_q    <= rxv_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: eng_op = OP_START;
      ST_WRITE: eng_op = OP_WRITE;
      ST_READ:  eng_op = OP_READ;
      ST_STOP:  eng_op = OP_STOP;
      default:  eng_op = OP_START;
    endcase
  end

  assign eng_req  = (state_q == ST_START) || (state_q == ST_WRITE) ||
                    (state_q == ST_READ)  || (state_q == ST_STOP);
  assign eng_byte = byte_q;
  assign eng_mack = (state_q == ST_READ) && (remain_q != 8'd1);
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign busy     = busy_q;
endmodule

// File: rtl/i2c_seq_events.sv
module i2c_seq_events #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          busy,
  input  logic          err_stb,
  input  logic          arb_stb,
  output logic          ev_tx_error,
  output logic          ev_arb_lost,
  output logic          ev_tx_empty,
  output logic          ev_tx_half,
  output logic          ev_bus_idle
);
  logic [CW-1:0] cnt_prev_q;
  logic          busy_prev_q;
  logic          err_q, arb_q, empty_q, half_q, idle_q;
  logic          empty_d, half_d, idle_d;

  always_comb begin
    empty_d = (cnt_prev_q != '0) && (cnt == '0);
    half_d  = (cnt_prev_q > CW'(HALF)) && (cnt == CW'(HALF));
    idle_d  = busy_prev_q && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prev_q  <= '0;
      busy_prev_q <= 1'b0;
      err_q       <= 1'b0;
      arb_q       <= 1'b0;
      empty_q     <= 1'b0;
      half_q      <= 1'b0;
      idle_q      <= 1'b0;
    end else begin
      cnt_prev_q  <= cnt;
      busy_prev_q <= busy;
      err_q       <= err_stb;
      arb_q       <= arb_stb;
      empty_q     <= empty_d;
      half_q      <= half_d;
      idle_q      <= idle_d;
    end
  end

  assign ev_tx_error = err_q;
  assign ev_arb_lost = arb_q;
  assign ev_tx_empty = empty_q;
  assign ev_tx_half  = half_q;
  assign ev_bus_idle = idle_q;
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fifo_reset,
  output logic              tx_full,
  output logic              tx_empty,
  output logic [AW-1:0]     tx_occ,
  output logic              bus_busy,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_byte,
  output logic              eng_mack,
  input  logic              eng_done,
  input  logic              eng_nak,
  input  logic              eng_arb,
  input  logic [7:0]        eng_rdata,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              ev_tx_error,
  output logic              ev_arb_lost,
  output logic              ev_tx_empty,
  output logic              ev_tx_half,
  output logic              ev_bus_idle
);
  logic [WORD_W-1:0] head;
  logic [AW:0]       cnt;
  logic              q_empty, pop, seq_flush, err_stb, arb_stb;

  i2c_seq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (seq_flush || fifo_reset),
    .push  (wr_en),
    .din   (wr_data),
    .pop   (pop),
    .head  (head),
    .cnt   (cnt),
    .full  (tx_full),
    .empty (q_empty)
  );

  i2c_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (q_empty || fifo_reset),
    .fifo_head  (head),
    .fifo_pop   (pop),
    .fifo_flush (seq_flush),
    .eng_req    (eng_req),
    .eng_op     (eng_op),
    .eng_byte   (eng_byte),
    .eng_mack   (eng_mack),
    .eng_done   (eng_done),
    .eng_nak    (eng_nak),
    .eng_arb    (eng_arb),
    .eng_rdata  (eng_rdata),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .busy       (bus_busy),
    .err_stb    (err_stb),
    .arb_stb    (arb_stb)
  );

  i2c_seq_events #(.DEPTH(DEPTH)) u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt),
    .busy        (bus_busy),
    .err_stb     (err_stb),
    .arb_stb     (arb_stb),
    .ev_tx_error (ev_tx_error),
    .ev_arb_lost (ev_arb_lost),
    .ev_tx_empty (ev_tx_empty),
    .ev_tx_half  (ev_tx_half),
    .ev_bus_idle (ev_bus_idle)
  );

  assign tx_empty = q_empty;
  assign tx_occ   = q_empty ? '0 : AW'(cnt - (AW+1)'(1));
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_reset,
  input logic          tx_full,
  input logic          tx_empty,
  input logic [AW-1:0] tx_occ,
  input logic          bus_busy,
  input logic          eng_req,
  input logic [1:0]    eng_op,
  input logic [7:0]    eng_byte,
  input logic          eng_mack,
  input logic          eng_done,
  input logic          eng_nak,
  input logic          eng_arb,
  input logic          ev_tx_error,
  input logic          ev_arb_lost,
  input logic          ev_bus_idle
);
  a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_byte) && $stable(eng_mack));

  a_r6_full_occ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> (tx_occ == AW'(DEPTH - 1)) && !tx_empty);

  a_r7_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> tx_empty && !tx_full);

  a_r8_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && eng_nak && !eng_arb && (eng_op == OP_START || eng_op == OP_WRITE)
    |=> ev_tx_error && eng_req && (eng_op == OP_STOP) && tx_empty);

  a_r9_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && eng_arb && (eng_op != OP_STOP)
    |=> ev_arb_lost && !bus_busy && !eng_req && tx_empty);

  a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> bus_busy);

  a_r10_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && (eng_op == OP_STOP) |=> !bus_busy);

  a_r10_idle_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |=> ev_bus_idle);
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_reset  (fifo_reset),
  .tx_full     (tx_full),
  .tx_empty    (tx_empty),
  .tx_occ      (tx_occ),
  .bus_busy    (bus_busy),
  .eng_req     (eng_req),
  .eng_op      (eng_op),
  .eng_byte    (eng_byte),
  .eng_mack    (eng_mack),
  .eng_done    (eng_done),
  .eng_nak     (eng_nak),
  .eng_arb     (eng_arb),
  .ev_tx_error (ev_tx_error),
  .ev_arb_lost (ev_arb_lost),
  .ev_bus_idle (ev_bus_idle)
);

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
  import i2c_seq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic       fifo_reset = 1'b0;
  logic       tx_full, tx_empty, bus_busy, eng_req, eng_mack, rx_valid;
  logic [3:0] tx_occ;
  logic [1:0] eng_op;
  logic [7:0] eng_byte, rx_data;
  logic       eng_done = 1'b0, eng_nak = 1'b0, eng_arb = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic       ev_tx_error, ev_arb_lost, ev_tx_empty, ev_tx_half, ev_bus_idle;

  always #4 clk = ~clk;

  i2c_cmd_seq u_i2c_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_reset(fifo_reset),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_occ(tx_occ), .bus_busy(bus_busy),
    .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte), .eng_mack(eng_mack),
    .eng_done(eng_done), .eng_nak(eng_nak), .eng_arb(eng_arb), .eng_rdata(eng_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .ev_tx_error(ev_tx_error),
    .ev_arb_lost(ev_arb_lost), .ev_tx_empty(ev_tx_empty), .ev_tx_half(ev_tx_half),
    .ev_bus_idle(ev_bus_idle)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit stall = 1'b0;
  int lat = 0, cur_lat = 2;
  logic [7:0] rd_ctr = 8'h15;

  logic [1:0] l_op [256]; logic [7:0] l_byte [256]; logic l_mack [256]; int nl = 0;
  logic [1:0] e_op [256]; logic [7:0] e_byte [256]; logic e_mack [256]; int ne = 0;
  logic [7:0] s_rx [256]; int ns = 0;
  logic [7:0] d_rx [256]; int nd = 0;
  int c_err = 0, c_arb = 0, c_empty = 0, c_half = 0, c_idle = 0;

  // behavioural byte engine: addr 0x3C loses arbitration, addr 0x7E and data 0xEE are NACKed
  always @(negedge clk) begin
    if (!rst_n) begin
      eng_done = 1'b0; eng_nak = 1'b0; eng_arb = 1'b0; lat = 0;
    end else if (eng_done) begin
      eng_done = 1'b0; eng_nak = 1'b0; eng_arb = 1'b0; lat = 0;
    end else if (eng_req && !stall) begin
      lat++;
      if (lat >= cur_lat) begin
        eng_done = 1'b1;
        cur_lat = 2 + int'($urandom % 3);
        case (eng_op)
          OP_START: begin
            eng_arb = (eng_byte[7:1] == 7'h3C);
            eng_nak = (eng_byte[7:1] == 7'h7E);
          end
          OP_WRITE: eng_nak = (eng_byte == 8'hEE);
          OP_READ: begin
            eng_rdata = rd_ctr;
            if (ns < 256) begin s_rx[ns] = rd_ctr; ns++; end
            rd_ctr = rd_ctr + 8'd37;
          end
          default: ;
        endcase
        if (nl < 256) begin
          l_op[nl] = eng_op; l_byte[nl] = eng_byte;
          l_mack[nl] = (eng_op == OP_READ) ? eng_mack : 1'b0; nl++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && nd < 256) begin d_rx[nd] = rx_data; nd++; end
      if (ev_tx_error) c_err++;
      if (ev_arb_lost) c_arb++;
      if (ev_tx_empty) c_empty++;
      if (ev_tx_half)  c_half++;
      if (ev_bus_idle) c_idle++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL R14 watchdog expired: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_logs();
    nl = 0; ne = 0; ns = 0; nd = 0;
  endtask

  task automatic ex(input logic [1:0] op, input logic [7:0] b, input logic m);
    e_op[ne] = op; e_byte[ne] = b; e_mack[ne] = m; ne++;
  endtask

  task automatic push(input logic [9:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    for (int i = 0; i < 3000 && q < 4; i++) begin
      @(negedge clk);
      if (!bus_busy && tx_empty && !eng_req) q++; else q = 0;
    end
  endtask

  task automatic compare_ops(input string req, input string tag);
    int bad = -1;
    check(nl == ne, req, {tag, " op count"}, nl, ne);
    for (int i = 0; i < ne && i < nl; i++)
      if (bad < 0 && (l_op[i] != e_op[i] || l_byte[i] != e_byte[i] || l_mack[i] != e_mack[i]))
        bad = i;
    check(bad < 0, req, {tag, " op/byte/ack sequence (byte at first mismatch)"},
          bad < 0 ? 0 : int'(l_byte[bad]), bad < 0 ? 0 : int'(e_byte[bad]));
  endtask

  task automatic compare_rx(input string req, input string tag);
    int bad = -1;
    check(nd == ns, req, {tag, " rx byte count"}, nd, ns);
    for (int i = 0; i < ns && i < nd; i++)
      if (bad < 0 && d_rx[i] != s_rx[i]) bad = i;
    check(bad < 0, req, {tag, " rx data (at first mismatch)"},
          bad < 0 ? 0 : int'(d_rx[bad]), bad < 0 ? 0 : int'(s_rx[bad]));
  endtask

  initial begin
    int e0, a0, i0, h0, m0;
    logic [9:0] w [16];
    int nw;
    void'($urandom(32'h0005eed1));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tx_empty == 1'b1 && tx_full == 1'b0, "R1", "empty/full in reset", {tx_empty, tx_full}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_occ == 4'd0 && !bus_busy && !eng_req, "R1", "occ/busy/req after reset", {tx_occ, bus_busy, eng_req}, 0);
    check(!ev_tx_error && !ev_arb_lost && !ev_tx_empty && !ev_tx_half && !ev_bus_idle, "R1", "events after reset", 1, 0);

    // R2/R3: write transfer with stop on last data
    clear_logs(); i0 = c_idle;
    push(10'h1A0); push(10'h011); push(10'h222);
    wait_idle();
    ex(OP_START, 8'hA0, 0); ex(OP_WRITE, 8'h11, 0); ex(OP_WRITE, 8'h22, 0); ex(OP_STOP, 8'h22, 0);
    compare_ops("R3", "write transfer");
    check(c_idle - i0 == 1, "R10", "bus idle events per transfer", c_idle - i0, 1);

    // R5: address-only write with stop
    clear_logs();
    push(10'h3A4);
    wait_idle();
    ex(OP_START, 8'hA4, 0); ex(OP_STOP, 8'hA4, 0);
    compare_ops("R5", "address-only");

    // R4: read of 3 bytes then stop
    clear_logs();
    push(10'h143); push(10'h203);
    wait_idle();
    ex(OP_START, 8'h43, 0); ex(OP_READ, 8'h43, 1); ex(OP_READ, 8'h43, 1); ex(OP_READ, 8'h43, 0);
    ex(OP_STOP, 8'h43, 0);
    compare_ops("R4", "read three");
    compare_rx("R4", "read three");

    // R2: repeated start from write to read
    clear_logs();
    push(10'h1A0); push(10'h05A); push(10'h1A1); push(10'h202);
    wait_idle();
    ex(OP_START, 8'hA0, 0); ex(OP_WRITE, 8'h5A, 0); ex(OP_START, 8'hA1, 0);
    ex(OP_READ, 8'hA1, 1); ex(OP_READ, 8'hA1, 0); ex(OP_STOP, 8'hA1, 0);
    compare_ops("R2", "repeated start");
    compare_rx("R2", "repeated start");

    // R4: zero-length read
    clear_logs();
    push(10'h161); push(10'h200);
    wait_idle();
    ex(OP_START, 8'h61, 0); ex(OP_STOP, 8'h61, 0);
    compare_ops("R4", "zero count read");
    check(nd == 0, "R4", "no rx for zero count", nd, 0);

    // R8: address NACK
    clear_logs(); e0 = c_err;
    push(10'h1FC); push(10'h233);
    wait_idle();
    ex(OP_START, 8'hFC, 0); ex(OP_STOP, 8'hFC, 0);
    compare_ops("R8", "address nack");
    check(c_err - e0 == 1, "R8", "tx error events on address nack", c_err - e0, 1);

    // R8: data NACK
    clear_logs(); e0 = c_err;
    push(10'h1A0); push(10'h0EE); push(10'h244);
    wait_idle();
    ex(OP_START, 8'hA0, 0); ex(OP_WRITE, 8'hEE, 0); ex(OP_STOP, 8'hEE, 0);
    compare_ops("R8", "data nack");
    check(c_err - e0 == 1, "R8", "tx error events on data nack", c_err - e0, 1);

    // R9: arbitration lost, no stop
    clear_logs(); a0 = c_arb; i0 = c_idle;
    push(10'h178); push(10'h044); push(10'h255);
    wait_idle();
    ex(OP_START, 8'h78, 0);
    compare_ops("R9", "arbitration lost");
    check(c_arb - a0 == 1, "R9", "arb lost events", c_arb - a0, 1);
    check(!bus_busy && tx_empty, "R9", "released and flushed", {bus_busy, tx_empty}, 1);
    check(c_idle - i0 == 1, "R10", "idle event after arb loss", c_idle - i0, 1);

    // R13: stray data word with no open transfer
    clear_logs(); e0 = c_err;
    push(10'h077);
    wait_idle();
    compare_ops("R13", "stray data");
    check(c_err - e0 == 1, "R13", "tx error on stray data", c_err - e0, 1);

    // R6/R7/R11: fill, overflow, reset, hold on dry queue
    clear_logs();
    stall = 1'b1;
    push(10'h1A0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) push(10'(i + 1));
    check(tx_full == 1'b1 && tx_occ == 4'd15, "R6", "full with 16 words (occ)", tx_occ, 15);
    push(10'h0FF);
    check(tx_full == 1'b1 && tx_occ == 4'd15, "R6", "push while full dropped (occ)", tx_occ, 15);
    fifo_reset = 1'b1; wr_en = 1'b1; wr_data = 10'h033;
    @(negedge clk);
    fifo_reset = 1'b0; wr_en = 1'b0;
    check(tx_empty == 1'b1 && tx_occ == 4'd0 && !tx_full, "R7", "queue reset empties (occ)", tx_occ, 0);
    stall = 1'b0;
    repeat (20) @(negedge clk);
    check(bus_busy == 1'b1 && eng_req == 1'b0, "R11", "hold with dry queue (busy,req)", {bus_busy, eng_req}, 2);
    push(10'h2AB);
    wait_idle();
    ex(OP_START, 8'hA0, 0); ex(OP_WRITE, 8'hAB, 0); ex(OP_STOP, 8'hAB, 0);
    compare_ops("R11", "resume after hold");

    // R12: half-empty and empty events
    clear_logs(); h0 = c_half; m0 = c_empty;
    stall = 1'b1;
    push(10'h1A0);
    for (int i = 0; i < 12; i++) push((i == 11) ? 10'(10'h200 + 10'h10 + i) : 10'(10'h10 + i));
    stall = 1'b0;
    wait_idle();
    ex(OP_START, 8'hA0, 0);
    for (int i = 0; i < 12; i++) ex(OP_WRITE, 8'(8'h10 + i), 0);
    ex(OP_STOP, 8'h1B, 0);
    compare_ops("R12", "long write");
    check(c_half - h0 == 1, "R12", "half-empty events", c_half - h0, 1);
    check(c_empty - m0 >= 1, "R12", "empty events", c_empty - m0, 1);

    // R3/R4: random transfers
    i0 = c_idle;
    for (int t = 0; t < 20; t++) begin
      logic [6:0] adr;
      int len;
      bit rd;
      logic [7:0] last;
      clear_logs();
      do adr = 7'($urandom); while (adr == 7'h3C || adr == 7'h7E);
      rd = 1'($urandom);
      nw = 0;
      w[nw] = {2'b01, adr, rd}; nw++;
      ex(OP_START, {adr, rd}, 0);
      last = {adr, rd};
      if (rd) begin
        len = 1 + int'($urandom % 6);
        w[nw] = 10'h200 | 10'(len); nw++;
        for (int k = 0; k < len; k++) ex(OP_READ, {adr, rd}, (k != len - 1));
      end else begin
        len = 1 + int'($urandom % 12);
        for (int k = 0; k < len; k++) begin
          logic [7:0] d;
          do d = 8'($urandom); while (d == 8'hEE);
          w[nw] = {(k == len - 1), 1'b0, d}; nw++;
          ex(OP_WRITE, d, 0);
          last = d;
        end
      end
      ex(OP_STOP, last, 0);
      for (int k = 0; k < nw; k++) push(w[k]);
      wait_idle();
      compare_ops(rd ? "R4" : "R3", "random transfer");
      if (rd) compare_rx("R4", "random read");
    end
    check(c_idle - i0 == 20, "R10", "idle events over random transfers", c_idle - i0, 20);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule